// File: doc/BRIEF.md
# Frame Line Counter with Vertical-Sync Interrupt

This block counts the horizontal sync pulses that arrive between two successive vertical sync pulses. At the start of each new frame it stores the total in an output register. Software reads that total to decide whether the line rate is plausible and to tell video modes apart. Counting is done on rising edges only. With composite sync, one line is lost per frame, so the true line total is the reported value plus one.

The block also keeps a pending flag for the vertical-sync interrupt. Every leading edge of vertical sync sets that flag. The flag is presented as an interrupt request only while the enable bit is set and the global mask is clear. The flag stays set until the processor acknowledges the vector fetch.

A qualifier output tells software when the stored total may be trusted. That requires both detect flags to be set, the overflow flag to be clear, and at least one frame to have been captured since reset.

Top module: `frame_line_counter`

## Requirements
- R1: The running counter goes up by exactly one for each 0-to-1 transition of `hsync`. A high level held for many cycles counts once.
- R2: On a 0-to-1 transition of `vsync`, `line_count` takes the number of `hsync` rising edges seen since the previous such transition, one clock later. The running counter restarts at that edge. An `hsync` rising edge in the same cycle is counted in the new frame. At all other times `line_count` holds its value.
- R3: The running counter saturates at 2^CNT_W-1 instead of wrapping, so `line_count` never exceeds that value.
- R4: `count_valid` is 1 exactly when `hdet`=1, `vdet`=1, `hover`=0 and at least one `vsync` rising edge has been captured since reset.
- R5: A `vsync` rising edge sets the pending interrupt flag whatever the values of `irq_en` and `irq_mask`. Enabling later raises `irq` without a new edge.
- R6: `irq` = pending flag AND `irq_en`=1 AND `irq_mask`=0. Here `irq_en`=1 means enabled and `irq_mask`=1 means masked.
- R7: `vec_ack`=1 clears the pending flag at the next clock. If a `vsync` rising edge falls in the same cycle, the flag stays set.
- R8: After reset, `line_count`=0, `count_valid`=0 and `irq`=0, and the enable is taken as 0.
- R9: Holding `vsync` high produces only one capture and one flag set. After an acknowledge, `irq` stays 0 while `vsync` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync, already synchronized |
| vsync | input | 1 | Vertical sync, already synchronized |
| hdet | input | 1 | Horizontal sync detected flag |
| vdet | input | 1 | Vertical sync detected flag |
| hover | input | 1 | Horizontal period overflow flag |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| irq_en | input | 1 | Vertical-sync interrupt enable, 1 = enabled |
| vec_ack | input | 1 | Vector-fetch acknowledge, clears pending flag |
| line_count | output | CNT_W | Lines counted in the last complete frame |
| count_valid | output | 1 | Stored count may be trusted |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is an `hsync` rising edge and a `vsync` rising edge. The bench raises both inputs on the same falling edge. It then checks two things: the captured total excludes that line, and the next frame reports one.

The second pair is a vector acknowledge and a new `vsync` leading edge. The bench drives both in one cycle and expects `irq` to remain high. A lone acknowledge afterwards must drop `irq`.

// File: rtl/frame_line_counter.sv
module frame_line_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             hdet,
  input  logic             vdet,
  input  logic             hover,
  input  logic             irq_mask,
  input  logic             irq_en,
  input  logic             vec_ack,
  output logic [CNT_W-1:0] line_count,
  output logic             count_valid,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             hs_q, vs_q, pend, seen;
  logic             hs_edge, vs_edge;
  logic [CNT_W-1:0] cnt, line_q;

  assign hs_edge = hsync & ~hs_q;
  assign vs_edge = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      cnt    <= '0;
      line_q <= '0;
      pend   <= 1'b0;
      seen   <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (vs_edge) begin
        line_q <= cnt;
        cnt    <= {{(CNT_W-1){1'b0}}, hs_edge};
        seen   <= 1'b1;
      end else if (hs_edge && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
      if (vs_edge)      pend <= 1'b1;
      else if (vec_ack) pend <= 1'b0;
    end
  end

  assign line_count  = line_q;
  assign count_valid = seen & hdet & vdet & ~hover;
  assign irq         = pend & irq_en & ~irq_mask;
endmodule

module frame_line_counter_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             hs_q,
  input logic             vs_q,
  input logic             vec_ack,
  input logic             irq_en,
  input logic             irq_mask,
  input logic             pend,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] line_count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  assert_edge_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !hs_q && !(vsync && !vs_q) && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hsync && !hs_q) && !(vsync && !vs_q)) |=> cnt == $past(cnt));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_q) |=> line_count == $past(cnt));
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && !vs_q) |=> $stable(line_count));
  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !(vsync && !vs_q)) |=> cnt == MAXV);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_q) |=> pend);
  assert_gating_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && !irq_mask));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !(vsync && !vs_q)) |=> !pend);
endmodule

bind frame_line_counter frame_line_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .hs_q(hs_q), .vs_q(vs_q),
  .vec_ack(vec_ack), .irq_en(irq_en), .irq_mask(irq_mask), .pend(pend), .irq(irq),
  .cnt(cnt), .line_count(line_count)
);

// File: tb/sim_frame_line_counter.sv
module sim_frame_line_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 0, vsync = 0, hdet = 0, vdet = 0, hover = 0;
  logic irq_mask = 0, irq_en = 0, vec_ack = 0;
  logic [CNT_W-1:0] line_count;
  logic count_valid, irq;
  int checks = 0, errors = 0;

  // {lines[15:8], hdet, vdet, hover, en, mask, exp_valid, exp_irq, 0}
  localparam logic [15:0] VEC [6] = '{
    {8'd5,  1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 1'b0},
    {8'd0,  1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0, 1'b0},
    {8'd17, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0},
    {8'd1,  1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b0},
    {8'd8,  1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1, 1'b0},
    {8'd12, 1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 1'b0}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_line_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .hdet(hdet), .vdet(vdet),
    .hover(hover), .irq_mask(irq_mask), .irq_en(irq_en), .vec_ack(vec_ack),
    .line_count(line_count), .count_valid(count_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hs_pulse();
    hsync = 1; @(negedge clk);
    hsync = 0; @(negedge clk);
  endtask

  task automatic ack();
    vec_ack = 1; @(negedge clk);
    vec_ack = 0; @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hdet = 1; vdet = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(line_count == 0, "R8 line_count", line_count, 0);
    chk(irq == 0, "R8 irq", irq, 0);
    chk(count_valid == 0, "R4 valid before first frame", count_valid, 0);

    foreach (VEC[i]) begin
      ack();
      {hdet, vdet, hover, irq_en, irq_mask} = VEC[i][7:3];
      for (int k = 0; k < int'(VEC[i][15:8]); k++) hs_pulse();
      vsync = 1; @(negedge clk);
      chk(line_count == CNT_W'(VEC[i][15:8]), "R2 table line_count", line_count, VEC[i][15:8]);
      chk(count_valid == VEC[i][2], "R4 table valid", count_valid, VEC[i][2]);
      chk(irq == VEC[i][1], "R6 table irq", irq, VEC[i][1]);
      vsync = 0; @(negedge clk);
    end

    hdet = 1; vdet = 1; hover = 0; irq_en = 1; irq_mask = 0;
    ack();
    chk(irq == 0, "R7 ack clears", irq, 0);
    hsync = 1; repeat (10) @(negedge clk); hsync = 0; @(negedge clk);
    vsync = 1; @(negedge clk);
    chk(line_count == 1, "R1 held hsync counts once", line_count, 1);
    vsync = 0; @(negedge clk);

    repeat (3) hs_pulse();
    hsync = 1; vsync = 1; @(negedge clk);
    chk(line_count == 3, "R2 coincident edge excluded", line_count, 3);
    hsync = 0; vsync = 0; @(negedge clk);
    vsync = 1; @(negedge clk);
    chk(line_count == 1, "R2 coincident edge in new frame", line_count, 1);
    vsync = 0; @(negedge clk);

    vsync = 1; vec_ack = 1; @(negedge clk);
    vec_ack = 0; vsync = 0; @(negedge clk);
    chk(irq == 1, "R7 edge beats ack", irq, 1);
    ack();
    chk(irq == 0, "R7 lone ack", irq, 0);

    irq_en = 0;
    vsync = 1; @(negedge clk); vsync = 0; @(negedge clk);
    chk(irq == 0, "R6 disabled", irq, 0);
    irq_en = 1; #1;
    chk(irq == 1, "R5 flag set while disabled", irq, 1);
    @(negedge clk);

    ack();
    vsync = 1; @(negedge clk);
    vec_ack = 1; @(negedge clk); vec_ack = 0;
    repeat (5) @(negedge clk);
    chk(irq == 0, "R9 held vsync no retrigger", irq, 0);
    chk(line_count == 0, "R9 no recapture", line_count, 0);
    vsync = 0; @(negedge clk);

    for (int k = 0; k < 1100; k++) hs_pulse();
    vsync = 1; @(negedge clk);
    chk(line_count == {CNT_W{1'b1}}, "R3 saturation", line_count, (1 << CNT_W) - 1);
    vsync = 0; @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule